// File: doc/BRIEF.md
# Synchronous Burst Cache SRAM

This block is a clocked single-port memory of 18-bit words on one shared bidirectional data bus. Each word is two byte lanes of nine bits: eight data bits and one parity bit. A transfer starts when either of two active-low address strobes is low at a rising edge. That edge captures the start address and the chip select. Later edges step through a four-word burst. A 2-bit beat counter rewrites the two low address bits, and it advances only on edges where the advance input is low.

The burst order comes from a mode pin. It is either interleaved, where the low bits are XORed with the beat, or linear, where the beat is added modulo four. Writes are fully synchronous: data and lane enables are taken at the edge. A global write stores both lanes, and otherwise a byte-write enable plus per-lane selects stores chosen lanes. Read data is driven one clock after its address is taken. The output enable acts without a clock. A sleep input freezes the block and floats the bus.

Top module: `burst_sram`

## Requirements
- R1: Lane i of the bus is bits dq[9*i+8 : 9*i]. Bit 9*i+8 is that lane's parity bit, and the two lanes are stored and returned independently.
- R2: An edge with adsp_n or adsc_n low (and sleep low) takes addr as the access address, resets the beat to 0 and records select = !ce_n. Either strobe alone has the same effect.
- R3: With mode low, the address of beat b is the start address with its two low bits replaced by (low bits + b) mod 4.
- R4: With mode high, the address of beat b is the start address with its two low bits replaced by (low bits XOR b).
- R5: On an edge with no strobe, the beat advances by one (wrapping 3 to 0) when adv_n is low, and it holds when adv_n is high.
- R6: gw_n low at an edge of a selected access writes both lanes at the access address.
- R7: With gw_n high and bwe_n low, only the lanes whose bw_n bit is low are written. With gw_n and bwe_n both high, the cycle is a read.
- R8: A selected read cycle drives the stored word on dq from the next edge on, while oe_n is low. A write cycle or a deselected cycle leaves dq high-impedance after that edge.
- R9: oe_n high floats dq at once, without a clock edge. Lowering oe_n again restores the pending read data.
- R10: While sleep is high, strobes, advances and writes are ignored, dq is high-impedance and memory keeps its contents. The burst state in place when sleep rose continues on the first edge after sleep falls.
- R11: After reset (rst_n low), dq is high-impedance and the block is deselected, so no write occurs until a strobe selects it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of control state |
| addr | input | ADDR_W | Start address, taken on a strobe edge |
| adsp_n | input | 1 | Processor-side address strobe, active low |
| adsc_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Chip select, sampled on strobe edges, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| gw_n | input | 1 | Global write of both lanes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 2 | Per-lane write selects, active low |
| mode | input | 1 | Burst order: 1 interleaved, 0 linear |
| sleep | input | 1 | Low-power freeze, active high |
| dq | inout | 18 | Shared data bus, two 9-bit lanes |

## Verification
The bench builds the block with its default ADDR_W of 6, a 64-word array. At that size it can write every location with random contents before reading, so every read has a known value. Start addresses with each of the four low-bit values are reached often. This lets bursts wrap in both orders and ensures that the upper address bits never change inside a burst. Random strobes, advances, lane writes, deselects and sleep periods run against a reference model in the bench, alongside directed bursts, output-enable toggles between edges, and a sleep window.

// File: rtl/burst_sram_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and the burst-order function.
// Assumes a four-beat burst on the two low address bits.
package burst_sram_pkg;
    localparam int BEAT_W = 2;
    localparam int LANE_W = 9;

    // Map start low bits and beat number to the low address bits.
    function automatic logic [BEAT_W-1:0] beat_low(
        input logic [BEAT_W-1:0] start_lo,
        input logic [BEAT_W-1:0] beat,
        input logic              interleave
    );
        return interleave ? (start_lo ^ beat) : (start_lo + beat);
    endfunction
endpackage

// File: rtl/burst_addr_gen.sv
`timescale 1ns/1ps
// Address generator: holds the start address, beat counter and select flag.
// Produces the address and select that apply at the coming edge.
// Assumes the caller freezes it (hold) during sleep.
module burst_addr_gen
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              load_sel,
    input  logic              interleave,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              eff_sel,
    output logic [BEAT_W-1:0] beat_q,
    output logic              sel_q
);
    logic [ADDR_W-1:0] start_q;
    logic [BEAT_W-1:0] beat_nx;

    // Choose the beat and select that this edge will use.
    always_comb begin
        if (load) begin
            beat_nx  = '0;
            eff_sel  = load_sel;
            eff_addr = load_addr;
        end else begin
            beat_nx  = step ? beat_q + 1'b1 : beat_q;
            eff_sel  = sel_q;
            eff_addr = {start_q[ADDR_W-1:BEAT_W],
                        beat_low(start_q[BEAT_W-1:0], beat_nx, interleave)};
        end
    end

    // Register burst state unless frozen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            beat_q  <= '0;
            sel_q   <= 1'b0;
        end else if (!hold) begin
            if (load) begin
                start_q <= load_addr;
                sel_q   <= load_sel;
            end
            beat_q <= beat_nx;
        end
    end
endmodule

// File: rtl/sram_lane.sv
`timescale 1ns/1ps
// One byte lane of the array: storage plus a registered read port.
// Assumes write and read are never requested together.
module sram_lane #(
    parameter int ADDR_W = 6,
    parameter int WIDTH  = 9
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              re,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  rdata
);
    localparam int DEPTH = 1 << ADDR_W;
    logic [WIDTH-1:0] store [DEPTH];

    // Synchronous write and registered read of this lane.
    always_ff @(posedge clk) begin
        if (we) store[addr] <= wdata;
        if (re) rdata <= store[addr];
    end
endmodule

// File: rtl/burst_sram.sv
`timescale 1ns/1ps
// Synchronous burst SRAM top: strobes start bursts, lanes store data,
// read data is driven one edge after its address while oe_n is low.
// Assumes the bus master does not drive dq during read cycles.
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              adsp_n,
    input  logic              adsc_n,
    input  logic              adv_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic              mode,
    input  logic              sleep,
    inout  wire  [LANES*LANE_W-1:0] dq
);
    localparam int BUS_W = LANES * LANE_W;

    logic              strobe;
    logic [ADDR_W-1:0] eff_addr;
    logic              eff_sel;
    logic [BEAT_W-1:0] beat_q;
    logic              sel_q;
    logic [LANES-1:0]  lane_we;
    logic              wr_any;
    logic              rd_go;
    logic              rd_valid_q;
    logic              drive_en;
    logic [BUS_W-1:0]  rd_word;

    // Start of a burst from either strobe.
    always_comb strobe = !adsp_n || !adsc_n;

    burst_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (sleep),
        .load       (strobe),
        .step       (!adv_n),
        .load_addr  (addr),
        .load_sel   (!ce_n),
        .interleave (mode),
        .eff_addr   (eff_addr),
        .eff_sel    (eff_sel),
        .beat_q     (beat_q),
        .sel_q      (sel_q)
    );

    // Decode lane writes: global write wins over byte selects.
    always_comb begin
        for (int i = 0; i < LANES; i++)
            lane_we[i] = eff_sel && !sleep && (!gw_n || (!bwe_n && !bw_n[i]));
        wr_any = !gw_n || !bwe_n;
        rd_go  = eff_sel && !sleep && !wr_any;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sram_lane #(.ADDR_W(ADDR_W), .WIDTH(LANE_W)) u_lane (
            .clk   (clk),
            .addr  (eff_addr),
            .we    (lane_we[g]),
            .re    (rd_go),
            .wdata (dq[g*LANE_W +: LANE_W]),
            .rdata (rd_word[g*LANE_W +: LANE_W])
        );
    end

    // Track whether the previous edge launched a read.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_valid_q <= 1'b0;
        else if (sleep)  rd_valid_q <= 1'b0;
        else             rd_valid_q <= rd_go;
    end

    // Output drivers follow oe_n and sleep without a clock.
    always_comb drive_en = rd_valid_q && !oe_n && !sleep;
    assign dq = drive_en ? rd_word : {BUS_W{1'bz}};
endmodule

// File: rtl/burst_sram_chk.sv
`timescale 1ns/1ps
// Checker for burst_sram: temporal rules on burst state and bus drive.
module burst_sram_chk #(
    parameter int ADDR_W = 6
) (
    input logic       clk,
    input logic       rst_n,
    input logic       adsp_n,
    input logic       adsc_n,
    input logic       adv_n,
    input logic       oe_n,
    input logic       sleep,
    input logic       wr_any,
    input logic       drive_en,
    input logic [1:0] beat_q,
    input logic       sel_q
);
    a_r2_strobe_clears_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && (!adsp_n || !adsc_n)) |=> (beat_q == 2'd0));

    a_r5_advance_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && adsp_n && adsc_n && !adv_n) |=> (beat_q == $past(beat_q) + 2'd1));

    a_r5_hold_without_adv: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && adsp_n && adsc_n && adv_n) |=> $stable(beat_q));

    a_r8_no_drive_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> $past(!wr_any && !sleep));

    a_r9_oe_floats: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !drive_en);

    a_r10_sleep_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> ($stable(beat_q) && $stable(sel_q) && !drive_en));
endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .adsp_n   (adsp_n),
    .adsc_n   (adsc_n),
    .adv_n    (adv_n),
    .oe_n     (oe_n),
    .sleep    (sleep),
    .wr_any   (wr_any),
    .drive_en (drive_en),
    .beat_q   (beat_q),
    .sel_q    (sel_q)
);

// File: tb/burst_sram_tb.sv
`timescale 1ns/1ps
// Bench: directed and seeded random cycles checked against a bench model.
module burst_sram_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1, ce_n = 1'b1, oe_n = 1'b1;
    logic gw_n = 1'b1, bwe_n = 1'b1, mode = 1'b0, sleep = 1'b0;
    logic [1:0] bw_n = 2'b11;
    logic [17:0] tb_dq = '0;
    logic tb_drv = 1'b0;
    wire  [17:0] dq;

    assign dq = tb_drv ? tb_dq : 18'bz;

    int tests = 0, fails = 0, cycles = 0;

    // model state
    logic [17:0] m_mem [DEPTH];
    logic [AW-1:0] m_start = '0;
    logic [1:0] m_beat = '0;
    logic m_sel = 1'b0, m_vld = 1'b0;
    logic [17:0] m_rdat = '0;

    burst_sram #(.ADDR_W(AW), .LANES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
        .adv_n(adv_n), .ce_n(ce_n), .oe_n(oe_n), .gw_n(gw_n), .bwe_n(bwe_n),
        .bw_n(bw_n), .mode(mode), .sleep(sleep), .dq(dq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [1:0] f_low(input logic [1:0] s, input logic [1:0] b, input logic il);
        return il ? (s ^ b) : (s + b);
    endfunction

    function automatic logic [17:0] f_bus();
        return (m_vld && !oe_n && !sleep) ? m_rdat : 18'bz;
    endfunction

    task automatic check_bus(input string tag);
        logic [17:0] exp;
        exp = f_bus();
        tests++;
        if (dq !== exp) begin
            fails++;
            $display("FAIL %s dq actual=%h expected=%h", tag, dq, exp);
        end
    endtask

    // Model update for one edge, using current input values.
    task automatic model_edge();
        logic [AW-1:0] ea;
        logic es, wr;
        logic [1:0] nb;
        if (!rst_n) begin
            m_start = '0; m_beat = '0; m_sel = 0; m_vld = 0;
            return;
        end
        if (sleep) begin
            m_vld = 0;
            return;
        end
        if (!adsp_n || !adsc_n) begin
            ea = addr; es = !ce_n; m_start = addr; m_sel = !ce_n; m_beat = 2'd0;
        end else begin
            nb = adv_n ? m_beat : m_beat + 2'd1;
            m_beat = nb; es = m_sel;
            ea = {m_start[AW-1:2], f_low(m_start[1:0], nb, mode)};
        end
        wr = !gw_n || !bwe_n;
        if (es) begin
            for (int i = 0; i < 2; i++)
                if (!gw_n || (!bwe_n && !bw_n[i])) m_mem[ea][i*9 +: 9] = tb_dq[i*9 +: 9];
        end
        m_vld = es && !wr;
        if (m_vld) m_rdat = m_mem[ea];
    endtask

    // One clock: edge, model, then check the bus at the falling edge.
    task automatic tick(input string tag);
        @(posedge clk);
        model_edge();
        cycles++;
        @(negedge clk);
        if (!tb_drv) check_bus(tag);
    endtask

    task automatic idle_inputs();
        adsp_n = 1; adsc_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bw_n = 2'b11; tb_drv = 0;
    endtask

    task automatic rd_start(input logic [AW-1:0] a, input logic use_p, input logic md, input string tag);
        idle_inputs(); addr = a; ce_n = 0; oe_n = 0; mode = md;
        if (use_p) adsp_n = 0; else adsc_n = 0;
        tick(tag);
    endtask

    task automatic rd_next(input logic adv, input string tag);
        idle_inputs(); adv_n = !adv; oe_n = 0;
        tick(tag);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        fails++; tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        int seed;
        seed = $urandom(32'd20240611);
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        @(negedge clk);
        model_edge();
        @(posedge clk); @(negedge clk);
        rst_n = 1;
        // R11: reset leaves bus floating even with oe_n low
        oe_n = 0;
        check_bus("R11 reset");
        // R11: a write without a strobe is ignored after reset
        oe_n = 1; gw_n = 0; tb_drv = 1; tb_dq = 18'h3ffff; tick("R11");
        idle_inputs();

        // fill array with global writes through alternating strobes (R6)
        for (int a = 0; a < DEPTH; a++) begin
            idle_inputs(); oe_n = 1; addr = a; ce_n = 0;
            if (a % 2 == 0) adsc_n = 0; else adsp_n = 0;
            gw_n = 0; tb_drv = 1; tb_dq = {$urandom} & 18'h3ffff;
            tick("R6 fill");
        end
        idle_inputs();
        // readback with strobes (R2, R6, R1)
        for (int a = 0; a < DEPTH; a += 7) rd_start(a, a[0], 0, "R2 R6 R1 readback");

        // R3 linear burst from low bits 2, wrapping
        rd_start(6'd14, 1, 0, "R3 beat0");
        for (int b = 0; b < 3; b++) rd_next(1, "R3 linear");
        rd_next(1, "R3 wrap");
        // R4 interleaved from low bits 3
        rd_start(6'd23, 0, 1, "R4 beat0");
        for (int b = 0; b < 3; b++) rd_next(1, "R4 interleaved");
        // R5 hold without advance
        rd_next(0, "R5 hold");
        rd_next(0, "R5 hold");
        rd_next(1, "R5 step");

        // R7 lane write of lane 1 only, then read back
        idle_inputs(); oe_n = 1; addr = 6'd9; adsc_n = 0; ce_n = 0; bwe_n = 0; bw_n = 2'b01;
        tb_drv = 1; tb_dq = 18'h2a5a5; tick("R7");
        rd_start(6'd9, 0, 0, "R7 R1 lane1 only");
        idle_inputs(); oe_n = 1; addr = 6'd9; adsp_n = 0; ce_n = 0; bwe_n = 0; bw_n = 2'b10;
        tb_drv = 1; tb_dq = 18'h15a5a; tick("R7");
        rd_start(6'd9, 1, 0, "R7 R1 lane0 only");
        // R7: bw selects without bwe_n are a read
        idle_inputs(); oe_n = 0; addr = 6'd9; adsc_n = 0; ce_n = 0; bw_n = 2'b00; tick("R7 read");

        // R8 deselected read floats, write cycle floats after
        idle_inputs(); addr = 6'd5; adsc_n = 0; ce_n = 1; oe_n = 0; tick("R8 deselect");
        rd_next(1, "R8 deselect burst");

        // R9 async oe
        rd_start(6'd30, 0, 0, "R9 base");
        #1 oe_n = 1; #1 check_bus("R9 oe high");
        oe_n = 0; #1 check_bus("R9 oe low");

        // R10 sleep window
        rd_start(6'd40, 0, 0, "R10 pre");
        idle_inputs(); sleep = 1; oe_n = 0; addr = 6'd3; adsp_n = 0; ce_n = 0; tick("R10 strobe ignored");
        idle_inputs(); sleep = 1; oe_n = 1; gw_n = 0; tb_drv = 1; tb_dq = 18'h0; tick("R10 write ignored");
        idle_inputs(); sleep = 1; oe_n = 0; adv_n = 0; tick("R10 bus floats");
        idle_inputs(); sleep = 0; oe_n = 0; adv_n = 0; tick("R10 resume");
        rd_start(6'd40, 1, 0, "R10 contents kept");

        // constrained random mix
        for (int n = 0; n < 3000; n++) begin
            logic wr;
            idle_inputs();
            addr = $urandom % DEPTH;
            adsp_n = ($urandom % 5) != 0;
            adsc_n = ($urandom % 5) != 0;
            adv_n = $urandom % 2;
            ce_n = ($urandom % 6) == 0;
            mode = $urandom % 2;
            sleep = ($urandom % 25) == 0;
            wr = ($urandom % 4) == 0;
            if (wr) begin
                if ($urandom % 2) gw_n = 0; else begin bwe_n = 0; bw_n = $urandom % 4; end
                oe_n = 1; tb_drv = 1; tb_dq = {$urandom} & 18'h3ffff;
            end else begin
                oe_n = ($urandom % 5) == 0;
            end
            tick("R3 R4 R5 R8 R10 random");
        end
        idle_inputs(); sleep = 0;

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule